// File: doc/BRIEF.md
# CRC-checked secure block transfer unit

This unit adds integrity-protected block commands to a byte-wide serial memory. It sits behind the serial front end, which does the bit shifting and opcode decoding. It receives whole bytes over a simple valid strobe, supplies outgoing bytes through a valid/take handshake, and drives a single-port RAM with one cycle of read latency.

A secure write carries a 17-bit address, a block of 128 data bytes and a 16-bit check value. The block first goes into an internal staging buffer. The RAM is written only after the check value received over the link equals the one the unit computed over the address bytes and the block. A corrupted block, a corrupted address, a wrong check value or a transfer cut short by deselection therefore leaves memory untouched. Each of these failures raises a volatile integrity flag, which the surrounding status logic presents as status bit 4.

A secure read takes an address and returns 128 consecutive bytes. While the bytes go out, the unit folds each one into a check value seeded with the same address bytes. It then sends that check value as two more bytes, so the host can verify the address and the data together.

Top module: `secx_block_xfer`

## Requirements
- R1: The check value is CRC-16 with polynomial 0x1021 and start value 0xFFFF, with each byte fed most significant bit first and no final inversion. It covers three address bytes, {7'b0, addr[16]}, then addr[15:8], then addr[7:0], followed by the 128 data bytes in transfer order. It is sent and received high byte first.
- R2: A secure write whose received check value matches writes the 128 staged bytes to addresses addr, addr+1, ... (modulo 2^17), one byte per cycle on consecutive cycles. ram_we first goes high in the second cycle after the clock edge that accepts the low check byte.
- R3: A secure write whose check value does not match, whether from bad data, a bad address or a bad check byte, produces no RAM write. In that case integrity_err is high in the second cycle after the edge that accepts the low check byte.
- R4: If cs_active goes low during the address, data or check phase of a secure write, the transfer is dropped with no RAM write. integrity_err is set and busy is low one cycle later.
- R5: An accepted wr_start clears integrity_err on the following cycle. A successful commit leaves it low. Otherwise it keeps its value until reset.
- R6: After its three address bytes, a secure read presents the 128 bytes at addr, addr+1, ... followed by the two check bytes. The first byte is valid two cycles after the last address byte is accepted. tx_data holds steady while tx_valid is high and tx_take is low. tx_valid and busy are low after the last check byte is taken.
- R7: If cs_active goes low during a secure read, tx_valid and busy drop on the next cycle and integrity_err does not change.
- R8: wr_start and rd_start are ignored while busy is high, including during a commit.
- R9: After reset, busy, integrity_err, tx_valid, ram_we and ram_re are all low.
- R10: ram_we and ram_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_active | input | 1 | High while the device is selected |
| wr_start | input | 1 | One-cycle pulse: secure write opcode decoded |
| rd_start | input | 1 | One-cycle pulse: secure read opcode decoded |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | tx_data holds a byte to send |
| tx_data | output | 8 | Byte to send |
| tx_take | input | 1 | Front end consumes tx_data this cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe (data returns one cycle later) |
| ram_addr | output | 17 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| busy | output | 1 | A secure transfer or commit is in progress |
| integrity_err | output | 1 | Volatile integrity failure flag (status bit 4) |

## Verification
The commit's first write strobe, or the raised flag on a mismatch, is due in the second cycle after the low check byte is accepted. The bench drives that byte on a falling edge and samples on the next two falling edges, so it sees the idle check cycle and then the due cycle. A flag set by an abort is due one cycle after deselection, and a flag cleared by a start is due one cycle after the start pulse; both are sampled on the first falling edge after that edge. On reads, the bench counts falling edges from the last address byte to the first tx_valid, expecting exactly two, and then polls tx_valid for each later byte while holding tx_take low for random spells to confirm that tx_data stays put.

// File: rtl/secx_pkg.sv
package secx_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      WR_IDLE,
      WR_ADDR,
      WR_DATA,
      WR_CRC,
      WR_CHECK,
      WR_COMMIT
   } wr_phase_t;

   typedef enum logic [2:0] {
      RD_IDLE,
      RD_ADDR,
      RD_FETCH,
      RD_LOAD,
      RD_DATA,
      RD_CRC
   } rd_phase_t;

endpackage

// File: rtl/secx_crc_acc.sv
module secx_crc_acc #(
   parameter int               CRC_W = 16,
   parameter logic [CRC_W-1:0] POLY  = 16'h1021,
   parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             update,
   input  logic [7:0]       din,
   output logic [CRC_W-1:0] crc
);

   generate
      if (CRC_W < 8 || (CRC_W % 8) != 0) begin : g_bad_width
         $error("secx_crc_acc: CRC_W must be a multiple of 8");
      end
   endgenerate

   // One byte, most significant bit first, through the shift-and-xor loop
   function automatic logic [CRC_W-1:0] fold_byte(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] d);
      logic [CRC_W-1:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ POLY;
         else                   r = r << 1;
      end
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc <= INIT;
      else if (clear)  crc <= INIT;
      else if (update) crc <= fold_byte(crc, din);
   end

endmodule

// File: rtl/secx_stage_buf.sv
module secx_stage_buf #(
   parameter int DEPTH = 128,
   parameter int W     = 8,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [W-1:0]  wdata,
   input  logic [IW-1:0] ridx,
   output logic [W-1:0]  rdata
);

   generate
      if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
         $error("secx_stage_buf: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   assign rdata = mem[ridx];

endmodule

// File: rtl/secx_wr_ctrl.sv
module secx_wr_ctrl
   import secx_pkg::*;
#(
   parameter int               ADDR_W      = 17,
   parameter int               BLOCK_BYTES = 128,
   parameter int               CRC_W       = 16,
   parameter logic [CRC_W-1:0] POLY        = 16'h1021,
   parameter logic [CRC_W-1:0] INIT        = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              start,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              set_err,
   output logic              clr_err,
   output logic              busy,
   output wr_phase_t         phase
);

   localparam int ADDR_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;
   localparam int CRC_BYTES  = CRC_W / BYTE_W;
   localparam int IDX_W      = $clog2(BLOCK_BYTES);
   localparam int CNT_W      = IDX_W + 1;

   wr_phase_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] base;
   logic [CRC_W-1:0]  rx_crc;
   logic [CRC_W-1:0]  calc_crc;
   logic              in_xfer;
   logic              take;
   logic              crc_match;
   logic              last_addr, last_data, last_crc;

   assign in_xfer   = (state == WR_ADDR) || (state == WR_DATA) || (state == WR_CRC);
   assign take      = in_xfer && cs_active && rx_valid;
   assign crc_match = (rx_crc == calc_crc);
   assign last_addr = (cnt == CNT_W'(ADDR_BYTES - 1));
   assign last_data = (cnt == CNT_W'(BLOCK_BYTES - 1));
   assign last_crc  = (cnt == CNT_W'(CRC_BYTES - 1));

   secx_crc_acc #(.CRC_W(CRC_W), .POLY(POLY), .INIT(INIT)) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (state == WR_IDLE && start),
      .update (take && state != WR_CRC),
      .din    (rx_byte),
      .crc    (calc_crc)
   );

   secx_stage_buf #(.DEPTH(BLOCK_BYTES), .W(BYTE_W), .IW(IDX_W)) u_stage (
      .clk   (clk),
      .we    (take && state == WR_DATA),
      .widx  (cnt[IDX_W-1:0]),
      .wdata (rx_byte),
      .ridx  (cnt[IDX_W-1:0]),
      .rdata (ram_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= WR_IDLE;
         cnt    <= '0;
         base   <= '0;
         rx_crc <= '0;
      end else if (in_xfer && !cs_active) begin
         state <= WR_IDLE;
      end else begin
         case (state)
            WR_IDLE: begin
               if (start) begin
                  state <= WR_ADDR;
                  cnt   <= '0;
               end
            end
            WR_ADDR: begin
               if (rx_valid) begin
                  base <= ADDR_W'({base, rx_byte});
                  if (last_addr) begin
                     state <= WR_DATA;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            WR_DATA: begin
               if (rx_valid) begin
                  if (last_data) begin
                     state <= WR_CRC;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            WR_CRC: begin
               if (rx_valid) begin
                  rx_crc <= CRC_W'({rx_crc, rx_byte});
                  if (last_crc) state <= WR_CHECK;
                  else          cnt   <= cnt + 1'b1;
               end
            end
            WR_CHECK: begin
               cnt   <= '0;
               state <= crc_match ? WR_COMMIT : WR_IDLE;
            end
            WR_COMMIT: begin
               if (last_data) state <= WR_IDLE;
               else           cnt   <= cnt + 1'b1;
            end
            default: state <= WR_IDLE;
         endcase
      end
   end

   assign set_err  = (in_xfer && !cs_active) || (state == WR_CHECK && !crc_match);
   assign clr_err  = (state == WR_IDLE && start) || (state == WR_COMMIT && last_data);
   assign ram_we   = (state == WR_COMMIT);
   assign ram_addr = base + ADDR_W'(cnt);
   assign busy     = (state != WR_IDLE);
   assign phase    = state;

endmodule

// File: rtl/secx_rd_ctrl.sv
module secx_rd_ctrl
   import secx_pkg::*;
#(
   parameter int               ADDR_W      = 17,
   parameter int               BLOCK_BYTES = 128,
   parameter int               CRC_W       = 16,
   parameter logic [CRC_W-1:0] POLY        = 16'h1021,
   parameter logic [CRC_W-1:0] INIT        = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              start,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_take,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [7:0]        ram_rdata,
   output logic              busy,
   output rd_phase_t         phase
);

   localparam int ADDR_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;
   localparam int CRC_BYTES  = CRC_W / BYTE_W;
   localparam int CNT_W      = $clog2(BLOCK_BYTES) + 1;

   rd_phase_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] base;
   logic [CRC_W-1:0]  calc_crc;
   logic [CRC_W-1:0]  crc_sr;
   logic              take;
   logic              crc_upd;
   logic [7:0]        crc_din;

   assign take    = tx_take && tx_valid;
   assign crc_upd = (state == RD_ADDR && cs_active && rx_valid) || (state == RD_LOAD);
   assign crc_din = (state == RD_ADDR) ? rx_byte : ram_rdata;

   secx_crc_acc #(.CRC_W(CRC_W), .POLY(POLY), .INIT(INIT)) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (state == RD_IDLE && start),
      .update (crc_upd),
      .din    (crc_din),
      .crc    (calc_crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RD_IDLE;
         cnt      <= '0;
         base     <= '0;
         tx_data  <= '0;
         tx_valid <= 1'b0;
         crc_sr   <= '0;
      end else if (state != RD_IDLE && !cs_active) begin
         state    <= RD_IDLE;
         tx_valid <= 1'b0;
      end else begin
         case (state)
            RD_IDLE: begin
               if (start) begin
                  state <= RD_ADDR;
                  cnt   <= '0;
               end
            end
            RD_ADDR: begin
               if (rx_valid) begin
                  base <= ADDR_W'({base, rx_byte});
                  if (cnt == CNT_W'(ADDR_BYTES - 1)) begin
                     state <= RD_FETCH;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RD_FETCH: state <= RD_LOAD;
            RD_LOAD: begin
               tx_data  <= ram_rdata;
               tx_valid <= 1'b1;
               state    <= RD_DATA;
            end
            RD_DATA: begin
               if (take) begin
                  if (cnt == CNT_W'(BLOCK_BYTES - 1)) begin
                     crc_sr  <= calc_crc;
                     tx_data <= calc_crc[CRC_W-1 -: 8];
                     cnt     <= '0;
                     state   <= RD_CRC;
                  end else begin
                     cnt      <= cnt + 1'b1;
                     tx_valid <= 1'b0;
                     state    <= RD_FETCH;
                  end
               end
            end
            RD_CRC: begin
               if (take) begin
                  if (cnt == CNT_W'(CRC_BYTES - 1)) begin
                     tx_valid <= 1'b0;
                     state    <= RD_IDLE;
                  end else begin
                     cnt     <= cnt + 1'b1;
                     crc_sr  <= crc_sr << 8;
                     tx_data <= crc_sr[CRC_W-9 -: 8];
                  end
               end
            end
            default: state <= RD_IDLE;
         endcase
      end
   end

   assign ram_re   = (state == RD_FETCH);
   assign ram_addr = base + ADDR_W'(cnt);
   assign busy     = (state != RD_IDLE);
   assign phase    = state;

endmodule

// File: rtl/secx_block_xfer.sv
module secx_block_xfer
   import secx_pkg::*;
#(
   parameter int               ADDR_W      = 17,
   parameter int               BLOCK_BYTES = 128,
   parameter int               CRC_W       = 16,
   parameter logic [CRC_W-1:0] CRC_POLY    = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT    = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              wr_start,
   input  logic              rd_start,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_take,
   output logic              ram_we,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata,
   output logic              busy,
   output logic              integrity_err
);

   localparam int IDX_W = $clog2(BLOCK_BYTES);

   generate
      if (CRC_W < 16 || (CRC_W % BYTE_W) != 0) begin : g_bad_crc
         $error("secx_block_xfer: CRC_W must be a multiple of 8, at least 16");
      end
      if (ADDR_W <= IDX_W + 1) begin : g_bad_addr
         $error("secx_block_xfer: ADDR_W must exceed the block index width");
      end
   endgenerate

   wr_phase_t         wr_phase;
   rd_phase_t         rd_phase;
   logic              wr_busy, rd_busy;
   logic              wr_we;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic              set_err, clr_err;

   assign busy = wr_busy || rd_busy;

   secx_wr_ctrl #(
      .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .CRC_W(CRC_W),
      .POLY(CRC_POLY), .INIT(CRC_INIT)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_active (cs_active),
      .start     (wr_start && !busy),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .ram_we    (wr_we),
      .ram_addr  (wr_addr),
      .ram_wdata (ram_wdata),
      .set_err   (set_err),
      .clr_err   (clr_err),
      .busy      (wr_busy),
      .phase     (wr_phase)
   );

   secx_rd_ctrl #(
      .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .CRC_W(CRC_W),
      .POLY(CRC_POLY), .INIT(CRC_INIT)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_active (cs_active),
      .start     (rd_start && !busy),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_take   (tx_take),
      .ram_re    (ram_re),
      .ram_addr  (rd_addr),
      .ram_rdata (ram_rdata),
      .busy      (rd_busy),
      .phase     (rd_phase)
   );

   assign ram_we   = wr_we;
   assign ram_addr = wr_we ? wr_addr : rd_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       integrity_err <= 1'b0;
      else if (set_err) integrity_err <= 1'b1;
      else if (clr_err) integrity_err <= 1'b0;
   end

endmodule

// File: rtl/secx_block_xfer_chk.sv
module secx_block_xfer_chk
   import secx_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_active,
   input logic              wr_start,
   input logic              rd_start,
   input logic              tx_valid,
   input logic [7:0]        tx_data,
   input logic              tx_take,
   input logic              ram_we,
   input logic              ram_re,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              busy,
   input logic              integrity_err,
   input wr_phase_t         wr_phase,
   input rd_phase_t         rd_phase
);

   // R3: a commit never runs while the failure flag is raised
   assert_no_write_when_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !integrity_err);

   // R2: commit writes walk consecutive addresses
   assert_commit_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && $past(ram_we)) |-> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

   // R4: deselection mid-write flags the failure and writes nothing
   assert_abort_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_phase == WR_ADDR || wr_phase == WR_DATA || wr_phase == WR_CRC) && !cs_active)
      |=> (integrity_err && !ram_we && !busy));

   // R5: an accepted write start clears the flag
   assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && !busy) |=> !integrity_err);

   // R6: an offered byte holds until taken
   assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_take && cs_active) |=> (tx_valid && $stable(tx_data)));

   // R7: deselection mid-read drops the transfer and leaves the flag alone
   assert_read_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_phase != RD_IDLE && !cs_active) |=> (!tx_valid && $stable(integrity_err)));

   // R8: a read start during a commit is not taken
   assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_phase == WR_COMMIT && rd_start) |=> (rd_phase == RD_IDLE));

   // R10: one RAM operation per cycle
   assert_ram_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re));

endmodule

bind secx_block_xfer secx_block_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cs_active     (cs_active),
   .wr_start      (wr_start),
   .rd_start      (rd_start),
   .tx_valid      (tx_valid),
   .tx_data       (tx_data),
   .tx_take       (tx_take),
   .ram_we        (ram_we),
   .ram_re        (ram_re),
   .ram_addr      (ram_addr),
   .busy          (busy),
   .integrity_err (integrity_err),
   .wr_phase      (wr_phase),
   .rd_phase      (rd_phase)
);

// File: tb/tb_secx_block_xfer.sv
`timescale 1ns/1ps
module tb_secx_block_xfer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_active = 1'b0;
   logic        wr_start = 1'b0;
   logic        rd_start = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_take = 1'b0;
   logic        ram_we, ram_re;
   logic [16:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic [7:0]  ram_rdata = '0;
   logic        busy, integrity_err;

   int checks = 0;
   int errors = 0;
   int we_cnt = 0;

   logic [7:0] mem    [1024] = '{default: 8'h00};
   logic [7:0] shadow [1024] = '{default: 8'h00};
   logic [7:0] wbuf   [128];

   always #2.5 clk = ~clk;

   secx_block_xfer dut (
      .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
      .wr_start(wr_start), .rd_start(rd_start),
      .rx_valid(rx_valid), .rx_byte(rx_byte),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take),
      .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .busy(busy), .integrity_err(integrity_err)
   );

   // RAM model: one cycle of read latency, low 10 address bits index it
   always @(posedge clk) begin
      if (ram_we) begin
         mem[ram_addr[9:0]] <= ram_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (ram_re) ram_rdata <= mem[ram_addr[9:0]];
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int k = 0; k < 8; k++) begin
         logic fb;
         fb = r[15] ^ d[7-k];
         r  = {r[14:0], 1'b0};
         if (fb) r = r ^ 16'h1021;
      end
      return r;
   endfunction

   function automatic logic [15:0] crc_addr(input logic [16:0] a);
      logic [15:0] r;
      r = 16'hFFFF;
      r = crc_byte(r, {7'b0, a[16]});
      r = crc_byte(r, a[15:8]);
      r = crc_byte(r, a[7:0]);
      return r;
   endfunction

   task automatic gap();
      repeat ($urandom_range(0, 2)) @(negedge clk);
   endtask

   task automatic put_byte(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 400 && busy; n++) @(negedge clk);
   endtask

   task automatic compare_mem(input string tag);
      int bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== shadow[i]) bad++;
      check(bad == 0, tag, bad, 0);
   endtask

   task automatic fill_wbuf();
      for (int i = 0; i < 128; i++) wbuf[i] = 8'($urandom);
   endtask

   // mode: 0 good, 1 bad data, 2 bad address, 3 bad check byte, 4 abort after abort_at bytes
   task automatic secure_write(input logic [16:0] addr, input int mode, input int abort_at,
                               input bit poke);
      logic [7:0]  stream [133];
      logic [15:0] c;
      int          we0, n;
      c = crc_addr(addr);
      for (int i = 0; i < 128; i++) c = crc_byte(c, wbuf[i]);
      stream[0] = {7'b0, addr[16]};
      stream[1] = addr[15:8];
      stream[2] = addr[7:0];
      for (int i = 0; i < 128; i++) stream[3+i] = wbuf[i];
      stream[131] = c[15:8];
      stream[132] = c[7:0];
      if (mode == 1) stream[3+37] = stream[3+37] ^ 8'h40;
      if (mode == 2) stream[2] = stream[2] ^ 8'h01;
      if (mode == 3) stream[132] = stream[132] ^ 8'h01;
      we0 = we_cnt;
      cs_active = 1'b1;
      wr_start  = 1'b1;
      @(negedge clk);
      wr_start = 1'b0;
      check(integrity_err == 1'b0, "R5 flag cleared after write start", integrity_err, 0);
      n = (mode == 4) ? abort_at : 133;
      for (int i = 0; i < n; i++) begin
         gap();
         put_byte(stream[i]);
      end
      if (mode == 4) begin
         cs_active = 1'b0;
         @(negedge clk);
         check(integrity_err == 1'b1, "R4 abort sets flag", integrity_err, 1);
         check(busy == 1'b0, "R4 abort returns idle", busy, 0);
         repeat (2) @(negedge clk);
         check(we_cnt == we0, "R4 abort writes nothing", we_cnt - we0, 0);
         compare_mem("R4 memory after abort");
         return;
      end
      check(ram_we == 1'b0, "R2 no write in check cycle", ram_we, 0);
      @(negedge clk);
      if (mode == 0) begin
         check(ram_we == 1'b1, "R2 commit starts on time", ram_we, 1);
         if (poke) begin
            rd_start = 1'b1;
            wr_start = 1'b1;
            @(negedge clk);
            rd_start = 1'b0;
            wr_start = 1'b0;
         end
      end else begin
         check(ram_we == 1'b0 && integrity_err == 1'b1, "R3 mismatch flags, no write",
               {ram_we, integrity_err}, 2'b01);
      end
      cs_active = 1'b0;
      wait_idle();
      @(negedge clk);
      if (mode == 0) begin
         for (int i = 0; i < 128; i++) begin
            logic [16:0] a;
            a = addr + 17'(i);
            shadow[a[9:0]] = wbuf[i];
         end
         check(we_cnt - we0 == 128, "R2 write count", we_cnt - we0, 128);
         check(integrity_err == 1'b0, "R5 flag low after commit", integrity_err, 0);
         compare_mem("R2 memory after commit");
      end else begin
         check(we_cnt == we0, "R3 no write on mismatch", we_cnt - we0, 0);
         check(integrity_err == 1'b1, "R5 flag holds after failure", integrity_err, 1);
         compare_mem("R3 memory after mismatch");
      end
      if (poke) begin
         check(busy == 1'b0 && tx_valid == 1'b0, "R8 starts during commit ignored",
               {busy, tx_valid}, 0);
      end
   endtask

   task automatic secure_read(input logic [16:0] addr);
      logic [15:0] c;
      logic [7:0]  exp, got;
      int          bad = 0;
      int          waits;
      c = crc_addr(addr);
      for (int i = 0; i < 128; i++) begin
         logic [16:0] a;
         a = addr + 17'(i);
         c = crc_byte(c, shadow[a[9:0]]);
      end
      cs_active = 1'b1;
      rd_start  = 1'b1;
      @(negedge clk);
      rd_start = 1'b0;
      gap(); put_byte({7'b0, addr[16]});
      gap(); put_byte(addr[15:8]);
      gap(); put_byte(addr[7:0]);
      for (int i = 0; i < 130; i++) begin
         logic [16:0] a;
         waits = 0;
         while (!tx_valid && waits < 20) begin
            @(negedge clk);
            waits++;
         end
         if (i == 0) check(waits == 2, "R6 first byte latency", waits, 2);
         got = tx_data;
         repeat ($urandom_range(0, 2)) @(negedge clk);
         if (!tx_valid || tx_data !== got) bad++;
         a = addr + 17'(i);
         if (i < 128) begin
            exp = shadow[a[9:0]];
            if (got !== exp) bad++;
         end else if (i == 128) begin
            check(got == c[15:8], "R1 read check high byte", got, c[15:8]);
         end else begin
            check(got == c[7:0], "R1 read check low byte", got, c[7:0]);
         end
         tx_take = 1'b1;
         @(negedge clk);
         tx_take = 1'b0;
      end
      check(bad == 0, "R6 read data and hold", bad, 0);
      check(tx_valid == 1'b0 && busy == 1'b0, "R6 read ends idle", {tx_valid, busy}, 0);
      cs_active = 1'b0;
      @(negedge clk);
   endtask

   task automatic read_abort(input logic [16:0] addr);
      logic flag0;
      flag0 = integrity_err;
      cs_active = 1'b1;
      rd_start  = 1'b1;
      @(negedge clk);
      rd_start = 1'b0;
      put_byte({7'b0, addr[16]});
      put_byte(addr[15:8]);
      put_byte(addr[7:0]);
      for (int n = 0; n < 10 && !tx_valid; n++) @(negedge clk);
      cs_active = 1'b0;
      @(negedge clk);
      check(tx_valid == 1'b0 && busy == 1'b0, "R7 read abort drops transfer",
            {tx_valid, busy}, 0);
      check(integrity_err == flag0, "R7 flag unchanged by read abort", integrity_err, flag0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired (all requirements): actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(!busy && !integrity_err && !tx_valid && !ram_we && !ram_re,
            "R9 reset state", {busy, integrity_err, tx_valid, ram_we, ram_re}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(ram_we == 1'b0 && ram_re == 1'b0, "R10 idle RAM strobes", {ram_we, ram_re}, 0);

      // directed: commit across the top of the address space, then read it back
      fill_wbuf();
      secure_write(17'h1FFC0, 0, 0, 1'b0);
      secure_read(17'h1FFC0);
      // directed mismatches
      fill_wbuf();
      secure_write(17'h00100, 1, 0, 1'b0);
      secure_write(17'h00200, 2, 0, 1'b0);
      secure_write(17'h00300, 3, 0, 1'b0);
      // directed aborts in each phase, including one byte short
      secure_write(17'h00040, 4, 0, 1'b0);
      secure_write(17'h00040, 4, 3, 1'b0);
      secure_write(17'h00040, 4, 70, 1'b0);
      secure_write(17'h00040, 4, 132, 1'b0);
      read_abort(17'h1FFC0);
      // start pulses during a commit
      fill_wbuf();
      secure_write(17'h0A5A5, 0, 0, 1'b1);
      secure_read(17'h0A5A5);

      for (int it = 0; it < 16; it++) begin
         logic [16:0] a;
         int          op;
         a  = 17'($urandom);
         op = $urandom_range(0, 5);
         fill_wbuf();
         case (op)
            0, 1:    secure_write(a, 0, 0, 1'b0);
            3:       secure_write(a, $urandom_range(1, 3), 0, 1'b0);
            4:       secure_write(a, 4, $urandom_range(0, 132), 1'b0);
            default: secure_read(a);
         endcase
      end
      secure_read(17'h0A5A5);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule